// File: doc/BRIEF.md
# Jump Target Address Generator

This block produces the next program-counter value for every branch and table-jump form a small microcontroller core uses. A decoded request names the branch kind and supplies the operands: the address of the following instruction, an immediate address field, a signed displacement, and the register contents B, C, DE and XA. One clock after the request, the block presents the new PC on a registered output and pulses a load strobe so the fetch unit can take the value.

Two program-space widths are supported. In narrow mode the program counter is 14 bits wide and bit 14 always reads zero. In wide mode all 15 bits are live. Several branch forms do not add an offset. They splice a register pair or a 12-bit in-block address into the low bits and keep the current upper bits of the PC, so the mode input decides how many of those upper bits are kept. The 15-bit absolute form is legal only in wide mode. In narrow mode a request of that kind is dropped.

Top module: `jump_target_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pc_out` is 0 and `pc_load` is 0.
- R2: `req_kind` is encoded as 0 absolute, 1 wide absolute, 2 relative, 3 page-DE, 4 page-XA, 5 far-CDE, 6 far-CXA, 7 block. Each accepted request sets `pc_load` high for exactly the next cycle, and back-to-back requests give back-to-back pulses. Without a request, `pc_load` is low.
- R3: Kind 0 loads `imm_addr[13:0]` in narrow mode, with bit 14 zero. In wide mode it loads `imm_addr[14:0]`.
- R4: Kind 1 loads `imm_addr[14:0]` in wide mode. In narrow mode the request is ignored: no strobe follows and `pc_out` keeps its value.
- R5: Kind 2 loads `pc_in` plus the sign-extended 8-bit `disp`. The sum wraps modulo 2^14 in narrow mode and modulo 2^15 in wide mode.
- R6: Kinds 3 and 4 keep `pc_in[13:8]` in narrow mode or `pc_in[14:8]` in wide mode, and put DE (kind 3) or XA (kind 4) in bits 7..0.
- R7: Kinds 5 and 6 load `{reg_b[2:0], reg_c, DE}` or `{reg_b[2:0], reg_c, XA}`. `reg_b[3]` has no effect.
- R8: Kind 7 keeps `pc_in[13:12]` in narrow mode or `pc_in[14:12]` in wide mode, and puts `imm_addr[11:0]` in bits 11..0.
- R9: In narrow mode every load leaves `pc_out[14]` at 0, whatever the kind and operands.
- R10: When `pc_load` is low, `pc_out` equals its value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Branch request this cycle |
| req_kind | input | 3 | Branch kind (encoding in R2) |
| wide_mode | input | 1 | 1 = 15-bit program space, 0 = 14-bit |
| pc_in | input | 15 | Address of the following instruction |
| imm_addr | input | 15 | Immediate address field |
| disp | input | 8 | Signed relative displacement |
| reg_b | input | 4 | Register B (low 3 bits used) |
| reg_c | input | 4 | Register C |
| reg_de | input | 8 | Register pair DE |
| reg_xa | input | 8 | Register pair XA |
| pc_out | output | 15 | Registered new program counter |
| pc_load | output | 1 | One-cycle load strobe |

## Verification
On every cycle the assertions check the strobe timing and its absence, the holding of `pc_out` between loads, the clear bit 14 in narrow mode, the drop of a wide-only request in narrow mode, and the kept upper bits and spliced low bits of the page and block forms. The exact arithmetic of relative branches is left to the bench's scenarios, because wrap-around at 2^14 and 2^15 with negative displacements is only visible in chosen cases. The same holds for the far forms with `reg_b[3]` set, and for interleaving the two modes. The bench compares every cycle against its own model over directed and pseudo-random requests.

// File: rtl/jtu_pkg.sv
package jtu_pkg;
  typedef enum logic [2:0] {
    JK_ABS      = 3'd0,
    JK_ABS_WIDE = 3'd1,
    JK_REL      = 3'd2,
    JK_PAGE_DE  = 3'd3,
    JK_PAGE_XA  = 3'd4,
    JK_FAR_CDE  = 3'd5,
    JK_FAR_CXA  = 3'd6,
    JK_BLOCK    = 3'd7
  } jump_kind_t;
endpackage

// File: rtl/jtu_target_calc.sv
module jtu_target_calc
  import jtu_pkg::*;
#(
  parameter int PC_W    = 15,
  parameter int PAGE_W  = 8,
  parameter int BLOCK_W = 12,
  parameter int DISP_W  = 8,
  parameter int BANK_W  = 3,
  parameter int NIB_W   = 4
) (
  input  logic [2:0]        kind,
  input  logic              wide_mode,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W-1:0]   imm_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [NIB_W-1:0]  reg_b,
  input  logic [NIB_W-1:0]  reg_c,
  input  logic [PAGE_W-1:0] reg_de,
  input  logic [PAGE_W-1:0] reg_xa,
  output logic [PC_W-1:0]   target,
  output logic              legal
);
  localparam int FAR_W = BANK_W + NIB_W + PAGE_W;

  jump_kind_t             k;
  logic [PC_W-1:0]        disp_ext;
  logic [PAGE_W-1:0]      pair;
  logic [FAR_W-1:0]       far_addr;

  assign k        = jump_kind_t'(kind);
  assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign pair     = (k == JK_PAGE_XA || k == JK_FAR_CXA) ? reg_xa : reg_de;
  assign far_addr = {reg_b[BANK_W-1:0], reg_c, pair};

  always_comb begin
    target = imm_addr;
    legal  = 1'b1;
    unique case (k)
      JK_ABS:      target = imm_addr;
      JK_ABS_WIDE: begin
        target = imm_addr;
        legal  = wide_mode;
      end
      JK_REL:      target = pc_in + disp_ext;
      JK_PAGE_DE,
      JK_PAGE_XA:  target = {pc_in[PC_W-1:PAGE_W], pair};
      JK_FAR_CDE,
      JK_FAR_CXA:  target = PC_W'(far_addr);
      JK_BLOCK:    target = {pc_in[PC_W-1:BLOCK_W], imm_addr[BLOCK_W-1:0]};
      default:     target = imm_addr;
    endcase
  end
endmodule

// File: rtl/jtu_width_limit.sv
module jtu_width_limit #(
  parameter int PC_W     = 15,
  parameter int NARROW_W = 14
) (
  input  logic            wide_mode,
  input  logic [PC_W-1:0] raw,
  output logic [PC_W-1:0] limited
);
  generate
    if (NARROW_W < PC_W) begin : g_clip
      localparam int TOP_W = PC_W - NARROW_W;
      assign limited = wide_mode ? raw : {{TOP_W{1'b0}}, raw[NARROW_W-1:0]};
    end else begin : g_pass
      assign limited = raw;
    end
  endgenerate
endmodule

// File: rtl/jtu_out_reg.sv
module jtu_out_reg #(
  parameter int PC_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] pc_q,
  output logic            load_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= take;
      if (take) pc_q <= next_pc;
    end
  end
endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit #(
  parameter int PC_W     = 15,
  parameter int NARROW_W = 14,
  parameter int PAGE_W   = 8,
  parameter int BLOCK_W  = 12,
  parameter int DISP_W   = 8,
  parameter int BANK_W   = 3,
  parameter int NIB_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              wide_mode,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W-1:0]   imm_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [NIB_W-1:0]  reg_b,
  input  logic [NIB_W-1:0]  reg_c,
  input  logic [PAGE_W-1:0] reg_de,
  input  logic [PAGE_W-1:0] reg_xa,
  output logic [PC_W-1:0]   pc_out,
  output logic              pc_load
);
  logic [PC_W-1:0] raw_target;
  logic [PC_W-1:0] clipped;
  logic            legal;

  jtu_target_calc #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .BLOCK_W(BLOCK_W),
    .DISP_W(DISP_W), .BANK_W(BANK_W), .NIB_W(NIB_W)
  ) u_calc (
    .kind(req_kind), .wide_mode(wide_mode), .pc_in(pc_in),
    .imm_addr(imm_addr), .disp(disp), .reg_b(reg_b), .reg_c(reg_c),
    .reg_de(reg_de), .reg_xa(reg_xa), .target(raw_target), .legal(legal)
  );

  jtu_width_limit #(.PC_W(PC_W), .NARROW_W(NARROW_W)) u_limit (
    .wide_mode(wide_mode), .raw(raw_target), .limited(clipped)
  );

  jtu_out_reg #(.PC_W(PC_W)) u_out (
    .clk(clk), .rst(rst), .take(req_valid && legal),
    .next_pc(clipped), .pc_q(pc_out), .load_q(pc_load)
  );
endmodule

// File: rtl/jtu_checker.sv
module jtu_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [2:0]  req_kind,
  input logic        wide_mode,
  input logic [14:0] pc_in,
  input logic [14:0] imm_addr,
  input logic [14:0] pc_out,
  input logic        pc_load
);
  logic accepted;
  assign accepted = req_valid && !(req_kind == 3'd1 && !wide_mode);

  AST_STROBE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    accepted |=> pc_load); // R2
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> !pc_load); // R2
  AST_WIDE_ONLY_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd1 && !wide_mode) |=> $stable(pc_out)); // R4
  AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (accepted && !wide_mode) |=> pc_out[14] == 1'b0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pc_load |-> $stable(pc_out)); // R10
  AST_PAGE_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && wide_mode && (req_kind == 3'd3 || req_kind == 3'd4))
    |=> pc_out[14:8] == $past(pc_in[14:8])); // R6
  AST_BLOCK_SPLICE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd7)
    |=> pc_out[11:0] == $past(imm_addr[11:0])); // R8
endmodule

bind jump_target_unit jtu_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .wide_mode(wide_mode), .pc_in(pc_in), .imm_addr(imm_addr),
  .pc_out(pc_out), .pc_load(pc_load)
);

// File: tb/jump_target_unit_bench.sv
module jump_target_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic        wide_mode = 1'b0;
  logic [14:0] pc_in = '0, imm_addr = '0;
  logic [7:0]  disp = '0, reg_de = '0, reg_xa = '0;
  logic [3:0]  reg_b = '0, reg_c = '0;
  logic [14:0] pc_out;
  logic        pc_load;

  int total = 0;
  int bad   = 0;
  int exp_pc = 0;
  bit exp_load = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  jump_target_unit u_jump_target_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .wide_mode(wide_mode), .pc_in(pc_in), .imm_addr(imm_addr), .disp(disp),
    .reg_b(reg_b), .reg_c(reg_c), .reg_de(reg_de), .reg_xa(reg_xa),
    .pc_out(pc_out), .pc_load(pc_load)
  );

  function automatic int model(int k, bit w, int pc, int imm, int d,
                               int b, int c, int de, int xa);
    int t;
    case (k)
      0, 1: t = imm;
      2:    t = pc + (d >= 128 ? d - 256 : d);
      3:    t = (pc & 32'h7F00) + de;
      4:    t = (pc & 32'h7F00) + xa;
      5:    t = (b % 8) * 4096 + c * 256 + de;
      6:    t = (b % 8) * 4096 + c * 256 + xa;
      default: t = (pc & 32'h7000) + (imm % 4096);
    endcase
    if (w) return ((t % 32768) + 32768) % 32768;
    return ((t % 16384) + 16384) % 16384;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      5, 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string t, int got, int want);
    total++;
    if (got != want) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, got, want);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(bit v, int k, bit w, int pc, int imm, int d,
                       int b, int c, int de, int xa);
    bit prev_load;
    req_valid = v; req_kind = 3'(k); wide_mode = w; pc_in = 15'(pc);
    imm_addr = 15'(imm); disp = 8'(d); reg_b = 4'(b); reg_c = 4'(c);
    reg_de = 8'(de); reg_xa = 8'(xa);
    prev_load = exp_load;
    @(posedge clk);
    if (v && !(k == 1 && !w)) begin
      exp_pc = model(k, w, pc, imm, d, b, c, de, xa);
      exp_load = 1;
      tag = tag_of(k);
    end else begin
      exp_load = 0;
      tag = (v ? "R4" : "R10");
    end
    @(negedge clk);
    check("R2", int'(pc_load), int'(exp_load));
    check(tag, int'(pc_out), exp_pc);
    if (pc_load && !w) check("R9", int'(pc_out[14]), 0);
    if (prev_load) ; // nothing extra
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(pc_out), 0);
    check("R1", int'(pc_load), 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", int'(pc_out), 0);
    check("R1", int'(pc_load), 0);

    // R3 absolute in both modes
    cycle(1, 0, 0, 0, 15'h7ABC, 0, 0, 0, 0, 0);
    cycle(1, 0, 1, 0, 15'h7ABC, 0, 0, 0, 0, 0);
    // R4 wide-only form
    cycle(1, 1, 1, 0, 15'h5123, 0, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 15'h0777, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 relative: forward, negative wrap in each width
    cycle(1, 2, 0, 15'h0100, 0, 8'h10, 0, 0, 0, 0);
    cycle(1, 2, 0, 15'h0000, 0, 8'hFF, 0, 0, 0, 0);
    cycle(1, 2, 1, 15'h0000, 0, 8'hFF, 0, 0, 0, 0);
    cycle(1, 2, 0, 15'h3FF0, 0, 8'h20, 0, 0, 0, 0);
    cycle(1, 2, 1, 15'h3FF0, 0, 8'h20, 0, 0, 0, 0);
    cycle(1, 2, 1, 15'h4005, 0, 8'h80, 0, 0, 0, 0);
    // R6 page forms
    cycle(1, 3, 0, 15'h7A55, 0, 0, 0, 0, 8'hC3, 8'h3C);
    cycle(1, 4, 1, 15'h7A55, 0, 0, 0, 0, 8'hC3, 8'h3C);
    // R7 far forms, B bit 3 set must not matter
    cycle(1, 5, 1, 0, 0, 0, 4'hF, 4'h9, 8'h12, 8'h34);
    cycle(1, 6, 1, 0, 0, 0, 4'h5, 4'h2, 8'h12, 8'h34);
    cycle(1, 5, 0, 0, 0, 0, 4'hF, 4'hA, 8'h77, 8'h00);
    // R8 block form
    cycle(1, 7, 1, 15'h6FFF, 15'h7ABC, 0, 0, 0, 0, 0);
    cycle(1, 7, 0, 15'h6FFF, 15'h0123, 0, 0, 0, 0, 0);
    // R10 idle holds
    cycle(0, 2, 1, 15'h1111, 15'h2222, 8'h01, 1, 1, 1, 1);
    cycle(0, 5, 0, 15'h1111, 15'h2222, 8'h01, 1, 1, 1, 1);

    // pseudo-random traffic, R2 back-to-back included
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = int'(lfsr) * 7919 + i * 131;
      cycle((lfsr[3:0] != 0), lfsr[6:4], lfsr[7], r % 32768,
            (r / 3) % 32768, lfsr[15:8], lfsr[11:8], lfsr[15:12],
            (r / 7) % 256, (r / 11) % 256);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule